// File: doc/BRIEF.md
# PLL Operating-Mode Controller

This block is the digital supervisor of a jitter-attenuating clock PLL. From per-input qualification flags, a preferred input index, lock and loss-of-lock indications and a flag that says whether the holdover frequency history can be trusted, it decides which mode the loop is in. The modes are initialisation, free-run, lock acquisition, locked and holdover. It also decides which reference input the loop follows, and which loop-bandwidth word the loop filter applies.

Three bandwidth words are held in shadow registers: nominal, fast-lock and holdover-exit. They are staged on input ports and committed together by one strobe. A hard reset request reruns the configuration-load period and restores the default words. A soft reset returns the mode to free-run and keeps all configuration.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After `rst_n` rises, or one cycle after `hard_rst_req` is sampled high, `mode` reads 0 (init) for exactly INIT_CYCLES clock edges and then reads 1 (free-run). While in init, `switch_req` and `fastlock_en` are 0 and `bw_active` is 0. Mode codes are: init 0, free-run 1, acquisition 2, locked 3, holdover 4.
- R2: In free-run, the mode stays 1 while no `in_valid` bit is set. When any bit is set, the mode becomes 2 on the next edge. The chosen input is `pref_idx` if that input is valid; otherwise it is the lowest-numbered valid input.
- R3: In acquisition, with the selected input still valid, `lock_ok` high moves the mode to 3 on the next edge. Locked is entered only from acquisition.
- R4: `switch_idx` always shows the selected input. Suppose the selected input's `in_valid` bit is low in acquisition or locked, and another input is valid. On the next edge the mode becomes 2, `switch_idx` becomes the lowest-numbered valid input, and `switch_req` is high for exactly that one cycle. `switch_req` also pulses whenever an exit from free-run or holdover changes the selected index.
- R5: Suppose the selected input fails and no input is valid. The next mode is 4 if `hist_valid` is high, and 1 otherwise.
- R6: Outside init, `fastlock_en` is high one cycle after `fl_force` is high, or after both `fl_auto_en` and `lol` are high. Otherwise it is low.
- R7: When `bw_commit` is sampled high outside init and without a hard reset, all three shadow words load their staged inputs on the same edge. Without a commit they hold. A commit sampled during init is ignored.
- R8: `soft_rst_req` (outside init) sets the mode to 1 on the next edge and keeps the selected index and the shadow words. `hard_rst_req` sets the mode to 0, the index to 0 and the shadow words to their defaults. Hard reset has priority, and soft reset is ignored during init.
- R9: Leaving holdover for acquisition starts a holdover-exit phase. The phase lasts until the mode leaves acquisition.
- R10: `bw_active` shows the fast-lock word when `fastlock_en` is high. Otherwise it shows the holdover-exit word during a holdover-exit phase, and the nominal word at all other times outside init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| hard_rst_req | input | 1 | Full restart with configuration reload |
| soft_rst_req | input | 1 | Restart without configuration reload |
| in_valid | input | N_IN | Per-input qualification flags |
| pref_idx | input | IDX_W | Preferred input when leaving free-run or holdover |
| lock_ok | input | 1 | Phase lock achieved |
| lol | input | 1 | Loss of lock indication |
| hist_valid | input | 1 | Holdover history usable |
| fl_auto_en | input | 1 | Let loss of lock drive fast-lock |
| fl_force | input | 1 | Force fast-lock bandwidth |
| bw_nom_in | input | BW_W | Staged nominal bandwidth word |
| bw_fast_in | input | BW_W | Staged fast-lock bandwidth word |
| bw_hexit_in | input | BW_W | Staged holdover-exit bandwidth word |
| bw_commit | input | 1 | Commit all staged words together |
| mode | output | 3 | Operating-mode code |
| fastlock_en | output | 1 | Fast-lock bandwidth in use |
| switch_req | output | 1 | One-cycle pulse on change of selected input |
| switch_idx | output | IDX_W | Selected input index |
| bw_active | output | BW_W | Bandwidth word applied to the loop |
| bw_nom | output | BW_W | Committed nominal word |
| bw_fast | output | BW_W | Committed fast-lock word |
| bw_hexit | output | BW_W | Committed holdover-exit word |

## Verification
Every registered result (`mode`, `switch_req`, `switch_idx`, `fastlock_en` and the shadow words) is due on the first rising edge after the stimulus is sampled. `bw_active` is a decode of registered state and is due at the same time. The one multi-cycle result is the init exit, which lands INIT_CYCLES edges after reset. The bench drives inputs and compares all outputs on the falling edge, against a behavioural model advanced on each rising edge. Each comparison therefore sees the state exactly one edge after the inputs it depends on.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
    typedef enum logic [2:0] {
        MODE_INIT     = 3'd0,
        MODE_FREERUN  = 3'd1,
        MODE_ACQ      = 3'd2,
        MODE_LOCKED   = 3'd3,
        MODE_HOLDOVER = 3'd4
    } pll_mode_e;
endpackage

// File: rtl/pll_init_timer.sv
module pll_init_timer #(
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && !done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pll_input_pick.sv
module pll_input_pick #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  valid,
    output logic             any_valid,
    output logic [IDX_W-1:0] low_idx
);
    always_comb begin
        low_idx = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (valid[i]) low_idx = IDX_W'(i);
        end
    end

    assign any_valid = |valid;

    always_comb begin
        if (any_valid) begin
            assert_low_is_valid_R4: assert (valid[low_idx]);
        end
    end
endmodule

// File: rtl/pll_bw_shadow.sv
module pll_bw_shadow #(
    parameter int              BW_W      = 16,
    parameter logic [BW_W-1:0] DEF_NOM   = '0,
    parameter logic [BW_W-1:0] DEF_FAST  = '0,
    parameter logic [BW_W-1:0] DEF_HEXIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hard,
    input  logic            block,
    input  logic            commit,
    input  logic [BW_W-1:0] nom_in,
    input  logic [BW_W-1:0] fast_in,
    input  logic [BW_W-1:0] hexit_in,
    output logic [BW_W-1:0] nom,
    output logic [BW_W-1:0] fast,
    output logic [BW_W-1:0] hexit
);
    typedef struct packed {
        logic [BW_W-1:0] nom;
        logic [BW_W-1:0] fast;
        logic [BW_W-1:0] hexit;
    } bw_set_t;

    localparam bw_set_t DEF_SET = '{nom: DEF_NOM, fast: DEF_FAST, hexit: DEF_HEXIT};

    bw_set_t set_d, set_q;
    logic    take;

    assign take = commit && !block;

    always_comb begin
        set_d = set_q;
        if (hard) begin
            set_d = DEF_SET;
        end else if (take) begin
            set_d.nom   = nom_in;
            set_d.fast  = fast_in;
            set_d.hexit = hexit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_q <= DEF_SET;
        else        set_q <= set_d;
    end

    assign nom   = set_q.nom;
    assign fast  = set_q.fast;
    assign hexit = set_q.hexit;

    assert_commit_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && !$past(hard)) |->
        (nom == $past(nom_in) && fast == $past(fast_in) && hexit == $past(hexit_in)));

    assert_hold_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(take) && !$past(hard)) |-> ($stable(nom) && $stable(fast) && $stable(hexit)));
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int              N_IN        = 4,
    parameter int              IDX_W       = (N_IN > 1) ? $clog2(N_IN) : 1,
    parameter int              BW_W        = 16,
    parameter int              INIT_CYCLES = 8,
    parameter logic [BW_W-1:0] DEF_NOM     = 16'h0100,
    parameter logic [BW_W-1:0] DEF_FAST    = 16'h0800,
    parameter logic [BW_W-1:0] DEF_HEXIT   = 16'h0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_rst_req,
    input  logic             soft_rst_req,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [IDX_W-1:0] pref_idx,
    input  logic             lock_ok,
    input  logic             lol,
    input  logic             hist_valid,
    input  logic             fl_auto_en,
    input  logic             fl_force,
    input  logic [BW_W-1:0]  bw_nom_in,
    input  logic [BW_W-1:0]  bw_fast_in,
    input  logic [BW_W-1:0]  bw_hexit_in,
    input  logic             bw_commit,
    output logic [2:0]       mode,
    output logic             fastlock_en,
    output logic             switch_req,
    output logic [IDX_W-1:0] switch_idx,
    output logic [BW_W-1:0]  bw_active,
    output logic [BW_W-1:0]  bw_nom,
    output logic [BW_W-1:0]  bw_fast,
    output logic [BW_W-1:0]  bw_hexit
);
    typedef struct packed {
        pll_mode_e        mode;
        logic [IDX_W-1:0] idx;
        logic             sw;
        logic             fl;
        logic             hx;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{mode: MODE_INIT, idx: '0, sw: 1'b0, fl: 1'b0, hx: 1'b0};

    ctrl_t            s_d, s_q;
    logic             init_done;
    logic             any_valid;
    logic [IDX_W-1:0] low_idx;
    logic             pref_ok;
    logic [IDX_W-1:0] exit_idx;
    logic             cur_valid;
    logic             in_init;

    assign in_init = (s_q.mode == MODE_INIT);

    pll_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hard_rst_req),
        .run     (in_init),
        .done    (init_done)
    );

    pll_input_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
        .valid     (in_valid),
        .any_valid (any_valid),
        .low_idx   (low_idx)
    );

    pll_bw_shadow #(
        .BW_W(BW_W), .DEF_NOM(DEF_NOM), .DEF_FAST(DEF_FAST), .DEF_HEXIT(DEF_HEXIT)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .hard     (hard_rst_req),
        .block    (in_init),
        .commit   (bw_commit),
        .nom_in   (bw_nom_in),
        .fast_in  (bw_fast_in),
        .hexit_in (bw_hexit_in),
        .nom      (bw_nom),
        .fast     (bw_fast),
        .hexit    (bw_hexit)
    );

    assign pref_ok   = (32'(pref_idx) < N_IN) && in_valid[pref_idx];
    assign exit_idx  = pref_ok ? pref_idx : low_idx;
    assign cur_valid = in_valid[s_q.idx];

    always_comb begin
        s_d    = s_q;
        s_d.sw = 1'b0;
        if (hard_rst_req) begin
            s_d = CTRL_RST;
        end else if (in_init) begin
            if (init_done) s_d.mode = MODE_FREERUN;
        end else if (soft_rst_req) begin
            s_d.mode = MODE_FREERUN;
            s_d.hx   = 1'b0;
        end else begin
            case (s_q.mode)
                MODE_FREERUN, MODE_HOLDOVER: begin
                    if (any_valid) begin
                        s_d.mode = MODE_ACQ;
                        s_d.idx  = exit_idx;
                        s_d.sw   = (exit_idx != s_q.idx);
                        s_d.hx   = (s_q.mode == MODE_HOLDOVER);
                    end
                end
                MODE_ACQ, MODE_LOCKED: begin
                    if (!cur_valid) begin
                        s_d.hx = 1'b0;
                        if (any_valid) begin
                            s_d.mode = MODE_ACQ;
                            s_d.idx  = low_idx;
                            s_d.sw   = 1'b1;
                        end else if (hist_valid) begin
                            s_d.mode = MODE_HOLDOVER;
                        end else begin
                            s_d.mode = MODE_FREERUN;
                        end
                    end else if (s_q.mode == MODE_ACQ && lock_ok) begin
                        s_d.mode = MODE_LOCKED;
                        s_d.hx   = 1'b0;
                    end
                end
                default: s_d = CTRL_RST;
            endcase
        end
        s_d.fl = (s_d.mode != MODE_INIT) && (fl_force || (fl_auto_en && lol));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTRL_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        if (in_init)      bw_active = '0;
        else if (s_q.fl)  bw_active = bw_fast;
        else if (s_q.hx)  bw_active = bw_hexit;
        else              bw_active = bw_nom;
    end

    assign mode        = s_q.mode;
    assign fastlock_en = s_q.fl;
    assign switch_req  = s_q.sw;
    assign switch_idx  = s_q.idx;

    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INIT) |-> (!switch_req && !fastlock_en && bw_active == '0));

    assert_lock_from_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCKED && $past(mode) != MODE_LOCKED) |-> ($past(mode) == MODE_ACQ));

    assert_switch_target_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |-> ((($past(in_valid) >> switch_idx) & N_IN'(1)) != '0));

    assert_holdover_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLDOVER && $past(mode) != MODE_HOLDOVER) |->
        ($past(hist_valid) && $past(in_valid) == '0));

    assert_fastlock_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_INIT && $past(fl_force)) |-> fastlock_en);

    assert_hexit_in_acq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hx |-> (mode == MODE_ACQ));

    assert_hard_to_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hard_rst_req) |-> (mode == MODE_INIT && switch_idx == '0));
endmodule

// File: tb/pll_mode_ctrl_bench.sv
module pll_mode_ctrl_bench;
    localparam int N_IN = 4;
    localparam int IDX_W = 2;
    localparam int BW_W = 16;
    localparam int INIT_CYCLES = 8;
    localparam int DEF_NOM = 'h0100;
    localparam int DEF_FAST = 'h0800;
    localparam int DEF_HEXIT = 'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hard_rst_req = 1'b0, soft_rst_req = 1'b0;
    logic [N_IN-1:0] in_valid = '0;
    logic [IDX_W-1:0] pref_idx = '0;
    logic lock_ok = 1'b0, lol = 1'b0, hist_valid = 1'b0;
    logic fl_auto_en = 1'b0, fl_force = 1'b0;
    logic [BW_W-1:0] bw_nom_in = '0, bw_fast_in = '0, bw_hexit_in = '0;
    logic bw_commit = 1'b0;
    logic [2:0] mode;
    logic fastlock_en, switch_req;
    logic [IDX_W-1:0] switch_idx;
    logic [BW_W-1:0] bw_active, bw_nom, bw_fast, bw_hexit;

    always #5 clk = ~clk;

    pll_mode_ctrl u_pll_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req),
        .in_valid(in_valid), .pref_idx(pref_idx), .lock_ok(lock_ok), .lol(lol),
        .hist_valid(hist_valid), .fl_auto_en(fl_auto_en), .fl_force(fl_force),
        .bw_nom_in(bw_nom_in), .bw_fast_in(bw_fast_in), .bw_hexit_in(bw_hexit_in),
        .bw_commit(bw_commit), .mode(mode), .fastlock_en(fastlock_en),
        .switch_req(switch_req), .switch_idx(switch_idx), .bw_active(bw_active),
        .bw_nom(bw_nom), .bw_fast(bw_fast), .bw_hexit(bw_hexit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string phase = "R1";

    // behavioural reference state
    int m_mode, m_cnt, m_idx, m_sw, m_fl, m_hx, m_nom, m_fast, m_hexit;
    int n_mode, n_cnt, n_idx, n_sw, n_hx, low, pick;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_idx = 0; m_sw = 0; m_fl = 0; m_hx = 0;
            m_nom = DEF_NOM; m_fast = DEF_FAST; m_hexit = DEF_HEXIT;
        end else begin
            n_mode = m_mode; n_cnt = m_cnt; n_idx = m_idx; n_sw = 0; n_hx = m_hx;
            low = -1;
            for (int i = N_IN - 1; i >= 0; i--) if (in_valid[i]) low = i;
            if (hard_rst_req) begin
                n_mode = 0; n_cnt = 0; n_idx = 0; n_hx = 0;
            end else if (m_mode == 0) begin
                if (m_cnt == INIT_CYCLES - 1) n_mode = 1;
                else n_cnt = m_cnt + 1;
            end else if (soft_rst_req) begin
                n_mode = 1; n_hx = 0;
            end else if (m_mode == 1 || m_mode == 4) begin
                if (low >= 0) begin
                    pick = in_valid[pref_idx] ? int'(pref_idx) : low;
                    n_mode = 2; n_sw = (pick != m_idx) ? 1 : 0; n_idx = pick;
                    n_hx = (m_mode == 4) ? 1 : 0;
                end
            end else begin
                if (!in_valid[m_idx]) begin
                    n_hx = 0;
                    if (low >= 0) begin
                        n_mode = 2; n_idx = low; n_sw = 1;
                    end else begin
                        n_mode = hist_valid ? 4 : 1;
                    end
                end else if (m_mode == 2 && lock_ok) begin
                    n_mode = 3; n_hx = 0;
                end
            end
            if (hard_rst_req) begin
                m_nom = DEF_NOM; m_fast = DEF_FAST; m_hexit = DEF_HEXIT;
            end else if (m_mode != 0 && bw_commit) begin
                m_nom = bw_nom_in; m_fast = bw_fast_in; m_hexit = bw_hexit_in;
            end
            m_fl = (n_mode != 0 && (fl_force || (fl_auto_en && lol))) ? 1 : 0;
            m_mode = n_mode; m_cnt = n_cnt; m_idx = n_idx; m_sw = n_sw; m_hx = n_hx;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk(phase, "mode", 32'(mode), m_mode);
            chk(phase, "switch_req", 32'(switch_req), m_sw);
            chk(phase, "switch_idx", 32'(switch_idx), m_idx);
            chk(phase, "fastlock_en", 32'(fastlock_en), m_fl);
            chk("R10", "bw_active", 32'(bw_active),
                (m_mode == 0) ? 0 : (m_fl != 0) ? m_fast : (m_hx != 0) ? m_hexit : m_nom);
            chk("R7", "bw_nom", 32'(bw_nom), m_nom);
            chk("R7", "bw_fast", 32'(bw_fast), m_fast);
            chk("R7", "bw_hexit", 32'(bw_hexit), m_hexit);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic commit_words(input int a, input int b, input int c);
        bw_nom_in = BW_W'(a); bw_fast_in = BW_W'(b); bw_hexit_in = BW_W'(c);
        bw_commit = 1'b1; tick(1); bw_commit = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        phase = "R1"; tick(INIT_CYCLES + 2);
        phase = "R2"; tick(3);
        pref_idx = 2'd3; in_valid = 4'b1010; tick(2);
        phase = "R3"; lock_ok = 1'b1; tick(3); lock_ok = 1'b0;
        phase = "R4"; in_valid = 4'b0010; tick(3);
        lock_ok = 1'b1; tick(2); lock_ok = 1'b0;
        phase = "R5"; hist_valid = 1'b1; in_valid = 4'b0000; tick(3);
        phase = "R9"; commit_words('h111, 'h222, 'h333);
        pref_idx = 2'd0; in_valid = 4'b0100; tick(4);
        lock_ok = 1'b1; tick(2); lock_ok = 1'b0;
        phase = "R5"; hist_valid = 1'b0; in_valid = 4'b0000; tick(3);
        phase = "R6"; in_valid = 4'b0001; tick(2);
        fl_auto_en = 1'b1; lol = 1'b1; tick(3); lol = 1'b0; tick(2);
        fl_auto_en = 1'b0; fl_force = 1'b1; tick(2); fl_force = 1'b0;
        lol = 1'b1; tick(2); lol = 1'b0;
        phase = "R10"; lock_ok = 1'b1; tick(2); lock_ok = 1'b0;
        hist_valid = 1'b1; in_valid = 4'b0000; tick(2);
        fl_force = 1'b1; in_valid = 4'b1000; tick(2);
        fl_force = 1'b0; tick(3);
        phase = "R8"; lock_ok = 1'b1; tick(2);
        soft_rst_req = 1'b1; tick(1); soft_rst_req = 1'b0; tick(3);
        hard_rst_req = 1'b1; tick(1); hard_rst_req = 1'b0;
        phase = "R7"; tick(2); commit_words('h444, 'h555, 'h666);
        soft_rst_req = 1'b1; tick(1); soft_rst_req = 1'b0;
        tick(INIT_CYCLES);
        commit_words('h777, 'h888, 'h999); tick(3);
        phase = "R2"; lock_ok = 1'b0; in_valid = 4'b0000; hist_valid = 1'b0; tick(4);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule